// File: doc/BRIEF.md
# Eight-pin GPIO port with per-pin alternate-function override

This block is one general-purpose digital I/O port of eight pins. Software reaches it through three register addresses: a direction register (1 = drive the pad), a port register (the output level when driving, the pull-up request when not), and a pin address whose read returns the synchronized pad level and whose write toggles port bits. One write strobe and one read strobe per address are shared by all pins; the data bus is eight bits wide.

The pad side produces output enable, output value, pull-up enable and digital input enable for each pin, and takes the raw pad level. For each pin an alternate peripheral can replace any of the four pad controls with an enable/value pair, and can take over the port bit with a toggle request. A global pull-up disable and a sleep signal are shared with other ports. While sleep is active, the digital input is disabled so that a floating pad cannot disturb internal logic.

Top module: `gpio_ovr_port`

## Requirements
- R1: While rst_ni is low and after it rises, before any write, the direction and port registers read 0x00, pad_oe_o is 0x00 and the pin read returns 0x00 while the pad is low.
- R2: A cycle with wr_dir_i or wr_port_i high loads wdata_i into that register at the clock edge; rd_dir_i or rd_port_i returns it on rdata_o in the same cycle; rdata_o is 0x00 when no read strobe is high.
- R3: A cycle with wr_pin_i high inverts each port bit whose wdata_i bit is 1 and leaves bits written 0 unchanged; when wr_port_i is high in the same cycle, the port write wins.
- R4: Without a pull-up override, pad_pu_o[n] is 1 only when direction bit n is 0, port bit n is 1 and pull_dis_i is 0; while rst_ni is low pad_pu_o is 0x00 even if a pull-up override requests 1.
- R5: For pull-up, direction, output value and digital input enable, a high override enable bit for pin n makes that pad output bit equal its override value bit; other pins keep their normal value.
- R6: While tgl_ovr_en_i[n] is high, port bit n inverts at every clock edge and writes to the port or pin address do not change that bit; other bits behave normally.
- R7: The pin read returns the pad level sampled through two flip-flop stages: a pad change applied before a clock edge is not visible after that edge alone and is visible after the next one.
- R8: Without a digital-input-enable override, pad_die_o is the inverse of sleep_i for all pins; the pin read bit n is 0 whenever the effective input enable for pin n is 0, with no delay.
- R9: Without an output override, pad_out_o equals the port register.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_dir_i | input | 1 | Write strobe, direction address |
| wr_port_i | input | 1 | Write strobe, port address |
| wr_pin_i | input | 1 | Write strobe, pin address (toggle) |
| rd_dir_i | input | 1 | Read strobe, direction address |
| rd_port_i | input | 1 | Read strobe, port address |
| rd_pin_i | input | 1 | Read strobe, pin address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, OR of selected sources |
| pull_dis_i | input | 1 | Global pull-up disable |
| sleep_i | input | 1 | Sleep, disables digital inputs |
| pu_ovr_en_i | input | 8 | Pull-up override enable per pin |
| pu_ovr_val_i | input | 8 | Pull-up override value per pin |
| dir_ovr_en_i | input | 8 | Direction override enable per pin |
| dir_ovr_val_i | input | 8 | Direction override value per pin |
| out_ovr_en_i | input | 8 | Output value override enable per pin |
| out_ovr_val_i | input | 8 | Output value override value per pin |
| tgl_ovr_en_i | input | 8 | Port toggle override per pin |
| die_ovr_en_i | input | 8 | Input enable override enable per pin |
| die_ovr_val_i | input | 8 | Input enable override value per pin |
| pad_in_i | input | 8 | Raw pad level |
| pad_oe_o | output | 8 | Pad output enable |
| pad_out_o | output | 8 | Pad output value |
| pad_pu_o | output | 8 | Pad pull-up enable |
| pad_die_o | output | 8 | Pad digital input enable |

## Verification
A corrupted direction or port bit shows at pad_oe_o, pad_out_o or pad_pu_o in the cycle after the faulty edge and on the matching register read at once, so each write and toggle is followed by a read in the next cycle. A synchronizer that is one stage short or long shows as the pad value appearing one edge early or late on the pin read, which the bench checks edge by edge. A wrong input-enable gate shows immediately as a non-zero pin read during sleep.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned GPIO_W_DEF = 8;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  function automatic logic ovr_pick(input logic en, input logic val, input logic base);
    return en ? val : base;
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned W = gpio_ovr_pkg::GPIO_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_dir_i,
  input  logic         wr_port_i,
  input  logic         wr_pin_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] tgl_ovr_en_i,
  output logic [W-1:0] ddr_o,
  output logic [W-1:0] port_o
);
  logic [W-1:0] ddr_q, port_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ddr_q <= '0;
    else if (wr_dir_i) ddr_q <= wdata_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) port_q[i] <= 1'b0;
      else if (tgl_ovr_en_i[i]) port_q[i] <= ~port_q[i];
      else if (wr_port_i) port_q[i] <= wdata_i[i];
      else if (wr_pin_i && wdata_i[i]) port_q[i] <= ~port_q[i];
    end

    // R3: pin-address write of 1 inverts the bit
    p_pin_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_pin_i && wdata_i[i] && !wr_port_i && !tgl_ovr_en_i[i]) |=> (port_q[i] != $past(port_q[i])));
    // R6: toggle override inverts every edge
    p_tgl_ovr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tgl_ovr_en_i[i] |=> (port_q[i] != $past(port_q[i])));
  end

  p_dir_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_i |=> (ddr_q == $past(wdata_i)));
  p_dir_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir_i |=> $stable(ddr_q));

  assign ddr_o  = ddr_q;
  assign port_o = port_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = gpio_ovr_pkg::GPIO_W_DEF,
  parameter int unsigned STAGES = gpio_ovr_pkg::SYNC_STAGES_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) age_q <= '0;
      else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
    // R7: two-edge latency from pad to synchronized value
    p_sync_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned W = gpio_ovr_pkg::GPIO_W_DEF
) (
  input  logic         rst_ni,
  input  logic [W-1:0] ddr_i,
  input  logic [W-1:0] port_i,
  input  logic         pull_dis_i,
  input  logic         sleep_i,
  input  logic [W-1:0] pu_ovr_en_i,
  input  logic [W-1:0] pu_ovr_val_i,
  input  logic [W-1:0] dir_ovr_en_i,
  input  logic [W-1:0] dir_ovr_val_i,
  input  logic [W-1:0] out_ovr_en_i,
  input  logic [W-1:0] out_ovr_val_i,
  input  logic [W-1:0] die_ovr_en_i,
  input  logic [W-1:0] die_ovr_val_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o,
  output logic [W-1:0] die_o
);
  import gpio_ovr_pkg::ovr_pick;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic pu_base;
    assign pu_base  = ~ddr_i[i] & port_i[i] & ~pull_dis_i;
    assign oe_o[i]  = ovr_pick(dir_ovr_en_i[i], dir_ovr_val_i[i], ddr_i[i]);
    assign out_o[i] = ovr_pick(out_ovr_en_i[i], out_ovr_val_i[i], port_i[i]);
    // pull-up held off through reset, override included
    assign pu_o[i]  = rst_ni & ovr_pick(pu_ovr_en_i[i], pu_ovr_val_i[i], pu_base);
    assign die_o[i] = ovr_pick(die_ovr_en_i[i], die_ovr_val_i[i], ~sleep_i);
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
  parameter int unsigned W           = gpio_ovr_pkg::GPIO_W_DEF,
  parameter int unsigned SYNC_STAGES = gpio_ovr_pkg::SYNC_STAGES_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_dir_i,
  input  logic         wr_port_i,
  input  logic         wr_pin_i,
  input  logic         rd_dir_i,
  input  logic         rd_port_i,
  input  logic         rd_pin_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         pull_dis_i,
  input  logic         sleep_i,
  input  logic [W-1:0] pu_ovr_en_i,
  input  logic [W-1:0] pu_ovr_val_i,
  input  logic [W-1:0] dir_ovr_en_i,
  input  logic [W-1:0] dir_ovr_val_i,
  input  logic [W-1:0] out_ovr_en_i,
  input  logic [W-1:0] out_ovr_val_i,
  input  logic [W-1:0] tgl_ovr_en_i,
  input  logic [W-1:0] die_ovr_en_i,
  input  logic [W-1:0] die_ovr_val_i,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_pu_o,
  output logic [W-1:0] pad_die_o
);
  logic [W-1:0] ddr, port, sync_q, pin_val, die_eff;

  gpio_port_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_dir_i, .wr_port_i, .wr_pin_i, .wdata_i, .tgl_ovr_en_i,
    .ddr_o(ddr), .port_o(port)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(sync_q)
  );

  gpio_pad_mux #(.W(W)) u_mux (
    .rst_ni, .ddr_i(ddr), .port_i(port), .pull_dis_i, .sleep_i,
    .pu_ovr_en_i, .pu_ovr_val_i, .dir_ovr_en_i, .dir_ovr_val_i,
    .out_ovr_en_i, .out_ovr_val_i, .die_ovr_en_i, .die_ovr_val_i,
    .oe_o(pad_oe_o), .out_o(pad_out_o), .pu_o(pad_pu_o), .die_o(die_eff)
  );

  assign pad_die_o = die_eff;
  assign pin_val   = sync_q & die_eff;

  always_comb begin
    rdata_o = '0;
    if (rd_dir_i)  rdata_o |= ddr;
    if (rd_port_i) rdata_o |= port;
    if (rd_pin_i)  rdata_o |= pin_val;
  end

  // R4: pull-up off during reset
  always_comb begin
    if (!rst_ni) p_pu_rst_r4: assert (pad_pu_o == '0);
  end

  // R8: sleeping input without override reads zero
  p_sleep_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pin_i && !rd_dir_i && !rd_port_i && sleep_i && (die_ovr_en_i == '0)) |-> (rdata_o == '0));

  // R9: no output override follows port read-back
  p_out_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_port_i && !rd_dir_i && !rd_pin_i && (out_ovr_en_i == '0)) |-> (pad_out_o == rdata_o));
endmodule

// File: tb/sim_gpio_ovr_port.sv
module sim_gpio_ovr_port;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_dir = 0, wr_port = 0, wr_pin = 0, rd_dir = 0, rd_port = 0, rd_pin = 0;
  logic [W-1:0] wdata = '0, rdata;
  logic pull_dis = 0, sleep = 0;
  logic [W-1:0] pu_en = '0, pu_val = '0, dir_en = '0, dir_val = '0;
  logic [W-1:0] out_en = '0, out_val = '0, tgl_en = '0, die_en = '0, die_val = '0;
  logic [W-1:0] pad_in = '0, oe, pout, pu, die;

  always #5 clk = ~clk;

  gpio_ovr_port u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_dir_i(wr_dir), .wr_port_i(wr_port), .wr_pin_i(wr_pin),
    .rd_dir_i(rd_dir), .rd_port_i(rd_port), .rd_pin_i(rd_pin),
    .wdata_i(wdata), .rdata_o(rdata), .pull_dis_i(pull_dis), .sleep_i(sleep),
    .pu_ovr_en_i(pu_en), .pu_ovr_val_i(pu_val), .dir_ovr_en_i(dir_en), .dir_ovr_val_i(dir_val),
    .out_ovr_en_i(out_en), .out_ovr_val_i(out_val), .tgl_ovr_en_i(tgl_en),
    .die_ovr_en_i(die_en), .die_ovr_val_i(die_val), .pad_in_i(pad_in),
    .pad_oe_o(oe), .pad_out_o(pout), .pad_pu_o(pu), .pad_die_o(die)
  );

  typedef enum int {S_RD, S_OE, S_OUT, S_PU, S_DIE} sel_e;
  typedef struct {
    string    req;
    sel_e     sel;
    logic [W-1:0] exp;
  } item_t;

  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic expect_val(input sel_e s, input logic [W-1:0] e, input string r);
    item_t it;
    it.req = r; it.sel = s; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
    wr_dir = 0; wr_port = 0; wr_pin = 0; rd_dir = 0; rd_port = 0; rd_pin = 0;
  endtask

  // monitor: compares queued expectations 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [W-1:0] act;
        it = sb_q.pop_front();
        case (it.sel)
          S_RD:  act = rdata;
          S_OE:  act = oe;
          S_OUT: act = pout;
          S_PU:  act = pu;
          default: act = die;
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    pu_en = 8'hFF; pu_val = 8'hFF;
    tick(); tick();
    expect_val(S_PU, 8'h00, "R4 pull-up forced off in reset");
    expect_val(S_OE, 8'h00, "R1 outputs off in reset");
    tick();
    rst_ni = 1; pu_en = '0; pu_val = '0; rd_dir = 1;
    expect_val(S_RD, 8'h00, "R1 dir after reset");
    expect_val(S_OE, 8'h00, "R1 oe after reset");
    tick(); rd_port = 1;
    expect_val(S_RD, 8'h00, "R1 port after reset");
    tick(); rd_pin = 1;
    expect_val(S_RD, 8'h00, "R1 pin after reset");

    // R2 register load and read-back
    tick(); wr_dir = 1; wdata = 8'h0F;
    tick(); rd_dir = 1;
    expect_val(S_RD, 8'h0F, "R2 dir read");
    expect_val(S_OE, 8'h0F, "R2 dir to oe");
    tick(); wr_port = 1; wdata = 8'hA5;
    tick(); rd_port = 1;
    expect_val(S_RD, 8'hA5, "R2 port read");
    expect_val(S_OUT, 8'hA5, "R9 out follows port");
    expect_val(S_PU, 8'hA0, "R4 pull-up from dir and port");
    tick(); pull_dis = 1;
    expect_val(S_PU, 8'h00, "R4 global pull disable");
    expect_val(S_RD, 8'h00, "R2 no strobe reads zero");

    // R3 toggle via pin address
    tick(); pull_dis = 0; wr_pin = 1; wdata = 8'h3C;
    tick(); rd_port = 1;
    expect_val(S_RD, 8'h99, "R3 ones toggle");
    tick(); wr_pin = 1; wdata = 8'h00;
    tick(); rd_port = 1;
    expect_val(S_RD, 8'h99, "R3 zeros no effect");
    tick(); wr_port = 1; wr_pin = 1; wdata = 8'h11;
    tick(); rd_port = 1;
    expect_val(S_RD, 8'h11, "R3 port write wins");

    // R5 overrides
    tick();
    dir_en = 8'hF0; dir_val = 8'h50; out_en = 8'h0F; out_val = 8'h0A;
    pu_en = 8'hFF; pu_val = 8'hC3; die_en = 8'h01; die_val = 8'h00;
    expect_val(S_OE, 8'h5F, "R5 dir override");
    expect_val(S_OUT, 8'h1A, "R5 out override");
    expect_val(S_PU, 8'hC3, "R5 pull-up override");
    expect_val(S_DIE, 8'hFE, "R5 input enable override");
    tick();
    dir_en = '0; dir_val = '0; out_en = '0; out_val = '0;
    pu_en = '0; pu_val = '0; die_en = '0; die_val = '0;
    expect_val(S_DIE, 8'hFF, "R8 awake input enable");

    // R6 toggle override
    tick(); tgl_en = 8'h01; rd_port = 1;
    expect_val(S_RD, 8'h11, "R6 before edge");
    tick(); rd_port = 1; wr_pin = 1; wdata = 8'h03;
    expect_val(S_RD, 8'h10, "R6 inverted at edge");
    tick(); rd_port = 1; tgl_en = 8'h00;
    expect_val(S_RD, 8'h13, "R6 pin write ignored on bit0");
    tick(); rd_port = 1; tgl_en = 8'h01; wr_port = 1; wdata = 8'hFF;
    expect_val(S_RD, 8'h13, "R6 stops when released");
    tick(); rd_port = 1; tgl_en = 8'h00;
    expect_val(S_RD, 8'hFE, "R6 port write ignored on bit0");
    tick(); rd_port = 1;
    expect_val(S_RD, 8'hFE, "R6 held after release");

    // R7 synchronizer latency
    tick(); pad_in = 8'h5A; rd_pin = 1;
    expect_val(S_RD, 8'h00, "R7 no edge yet");
    tick(); rd_pin = 1;
    expect_val(S_RD, 8'h00, "R7 one edge");
    tick(); rd_pin = 1;
    expect_val(S_RD, 8'h5A, "R7 two edges");

    // R8 sleep gating
    tick(); rd_pin = 1; sleep = 1;
    expect_val(S_RD, 8'h00, "R8 sleep gates read");
    expect_val(S_DIE, 8'h00, "R8 sleep disables inputs");
    tick(); rd_pin = 1; die_en = 8'hFF; die_val = 8'h0F;
    expect_val(S_RD, 8'h0A, "R8 override gates read");
    expect_val(S_DIE, 8'h0F, "R8 override value");
    tick(); rd_pin = 1; sleep = 0; die_en = '0; die_val = '0;
    expect_val(S_RD, 8'h5A, "R8 awake read");

    tick(); tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule